// File: doc/BRIEF.md
# Class H Rail Select Controller

This block chooses which of two supply rail levels the charge pump of a Class H headphone amplifier should provide. A low rail saves power, and a high rail gives headroom. It receives signed audio samples with a sample strobe, a 3-bit mode code and an unsigned clip threshold. It produces a rail request that changes only on a charge-pump clock enable.

Two mode codes pin the request to one rail whatever the signal does. The adaptive code tracks the signal. A sample whose magnitude exceeds the threshold, and so would clip on the low rail, moves the decision to the high rail at once. The decision returns to the low rail only after a long run of quiet samples, and any loud sample restarts that run. The run length is a parameter, by default 5.5 s of samples at 48 kHz. Every other mode code is reserved and keeps the high rail, so the output stage is never starved.

Top module: `chs_rail_ctrl`

## Requirements
- R1: While reset is held, at the first clock edge and after it, rail_req = 1, rail_state = 1 and hold_active = 0.
- R2: With mode = 3'b001, rail_state is 0 at the edge after the mode is sampled. It stays 0 whatever the samples are.
- R3: With mode = 3'b010, rail_state is 1 at the edge after the mode is sampled. It stays 1 whatever the samples are.
- R4: Every mode code other than 3'b001, 3'b010 and 3'b111 behaves like 3'b010.
- R5: The magnitude of a sample is its absolute value, and the code -2^(W-1) saturates to 2^(W-1)-1. A sample is loud only if its magnitude is strictly greater than clip_thresh.
- R6: With mode = 3'b111, a loud valid sample sets rail_state to 1 at the edge that samples it and clears the hold count.
- R7: rail_req takes the value rail_state had just before each edge on which cp_tick is 1. It holds its value on every other edge.
- R8: In mode 3'b111 with rail_state = 1, each quiet valid sample advances a hold count. On the HOLD_SAMPLES-th consecutive such sample, rail_state falls to 0 and the count clears. hold_active is 1 exactly while the count is nonzero.
- R9: A loud valid sample during the hold count restarts the count from zero.
- R10: When mode changes to 3'b111 from any other code, rail_state is 1 and hold_active is 0 after that edge.
- R11: With sample_vld = 0, the sample input has no effect on rail_state or the hold count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Rail mode code: 001 low fixed, 010 high fixed, 111 adaptive, others reserved (high) |
| clip_thresh | input | SAMPLE_W-1 | Unsigned magnitude above which a sample counts as loud |
| sample_vld | input | 1 | One-cycle strobe marking a new sample |
| sample | input | SAMPLE_W | Signed two's-complement audio sample |
| cp_tick | input | 1 | One-cycle enable marking a charge-pump clock cycle |
| rail_req | output | 1 | Rail request to the charge pump, 1 = high rail |
| rail_state | output | 1 | Current rail decision before charge-pump alignment |
| hold_active | output | 1 | Down-switch hold count is running |

## Verification
The assertions take sample_vld and cp_tick to be single-cycle strobes that can arrive on any clock edge. They take mode to be static between edges, and clip_thresh to change only while the block is idle or in a fixed mode. The stimulus drives every input on the falling edge and issues cp_tick every fourth cycle, so strobes and loud samples fall both on and off charge-pump edges. Mode changes only between samples, and clip_thresh only in adaptive mode with no sample pending. A shortened hold length lets a full quiet run, a restarted run and the most negative code all be covered.

// File: rtl/chs_pkg.sv
// Package: shared mode codes and the decoded rail mode type for the
// Class H rail select controller. Assumes a 3-bit mode code.
package chs_pkg;

    localparam logic [2:0] MODE_CODE_LO    = 3'b001;
    localparam logic [2:0] MODE_CODE_HI    = 3'b010;
    localparam logic [2:0] MODE_CODE_ADAPT = 3'b111;

    typedef enum logic [1:0] {
        RAIL_KIND_LO    = 2'd0,
        RAIL_KIND_HI    = 2'd1,
        RAIL_KIND_ADAPT = 2'd2
    } rail_kind_e;

    // Map a mode code to its behaviour; reserved codes keep the high rail.
    function automatic rail_kind_e decode_mode(input logic [2:0] code);
        case (code)
            MODE_CODE_LO:    return RAIL_KIND_LO;
            MODE_CODE_ADAPT: return RAIL_KIND_ADAPT;
            default:         return RAIL_KIND_HI;
        endcase
    endfunction

endpackage

// File: rtl/chs_mag_cmp.sv
// Module: chs_mag_cmp
// Purpose: turns a signed sample into a saturated magnitude and compares it
// with the clip threshold. Purely combinational.
// Assumes: W >= 2; threshold is unsigned and W-1 bits wide.
module chs_mag_cmp #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] sample_i,
    input  logic                valid_i,
    input  logic [W-2:0]        thresh_i,
    output logic                loud_o,
    output logic                quiet_o,
    output logic [W-2:0]        mag_o
);

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] raw;
    logic [W-1:0] negated;

    assign raw     = sample_i;
    assign negated = ~raw + ONE;

    // Absolute value with the most negative code clamped to full scale.
    always_comb begin
        if (!raw[W-1]) begin
            mag_o = raw[W-2:0];
        end else if (raw == MOST_NEG) begin
            mag_o = '1;
        end else begin
            mag_o = negated[W-2:0];
        end
    end

    // Loud/quiet classification of a valid sample.
    always_comb begin
        loud_o  = valid_i && (mag_o > thresh_i);
        quiet_o = valid_i && !(mag_o > thresh_i);
    end

endmodule

// File: rtl/chs_hold_timer.sv
// Module: chs_hold_timer
// Purpose: counts consecutive quiet samples before a down switch.
// Assumes: HOLD >= 2; clear has priority over step; step is a one-cycle strobe.
module chs_hold_timer #(
    parameter int HOLD = 264000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic expired_o,
    output logic running_o
);

    localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt;
    logic          at_last;

    assign at_last   = (cnt == LAST);
    assign expired_o = step_i && !clear_i && at_last;
    assign running_o = (cnt != '0);

    // Hold counter: clear, wrap at the terminal count, or advance on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear_i) begin
            cnt <= '0;
        end else if (step_i) begin
            if (at_last) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8: the count never passes its terminal value.
    assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R9: a clear leaves the counter idle on the next edge.
    assert_clear_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !running_o);

    // R11: without a step or clear the counter holds.
    assert_no_step_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clear_i) |=> $stable(cnt));

endmodule

// File: rtl/chs_rail_fsm.sv
// Module: chs_rail_fsm
// Purpose: keeps the rail decision and aligns the request to charge-pump
// clock enables. Drives the hold timer's clear and step.
// Assumes: cp_tick_i is a one-cycle enable; mode kind is decoded upstream.
module chs_rail_fsm
    import chs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rail_kind_e kind_i,
    input  logic       enter_i,
    input  logic       loud_i,
    input  logic       quiet_i,
    input  logic       expired_i,
    input  logic       cp_tick_i,
    output logic       clear_o,
    output logic       step_o,
    output logic       want_high_o,
    output logic       rail_req_o
);

    logic adaptive;

    assign adaptive = (kind_i == RAIL_KIND_ADAPT);

    // Timer control: hold the counter idle unless adapting on the high rail.
    always_comb begin
        clear_o = !adaptive || enter_i || loud_i;
        step_o  = quiet_i && want_high_o;
    end

    // Rail decision: fixed modes force it, adaptive goes up at once, down on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_high_o <= 1'b1;
        end else begin
            case (kind_i)
                RAIL_KIND_LO: want_high_o <= 1'b0;
                RAIL_KIND_HI: want_high_o <= 1'b1;
                default: begin
                    if (enter_i || loud_i) begin
                        want_high_o <= 1'b1;
                    end else if (expired_i) begin
                        want_high_o <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Charge-pump alignment: the request follows the decision on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rail_req_o <= 1'b1;
        end else if (cp_tick_i) begin
            rail_req_o <= want_high_o;
        end
    end

    // R2: the fixed low mode drives the decision low.
    assert_fixed_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == RAIL_KIND_LO) |=> !want_high_o);

    // R3/R4: the fixed high mode and reserved codes drive the decision high.
    assert_fixed_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == RAIL_KIND_HI) |=> want_high_o);

    // R6: a loud sample in adaptive mode raises the decision at once.
    assert_loud_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adaptive && loud_i) |=> want_high_o);

    // R7: the request never moves without a charge-pump tick.
    assert_req_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_tick_i |=> $stable(rail_req_o));

    // R8: a down switch comes only from an expired hold or the fixed low mode.
    assert_down_only_expired_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(want_high_o) |-> $past(expired_i || kind_i == RAIL_KIND_LO));

endmodule

// File: rtl/chs_rail_ctrl.sv
// Module: chs_rail_ctrl (top)
// Purpose: Class H rail select controller. It chooses the low or high supply
// rail from the mode code and the sample level, with an immediate up switch
// and a long quiet hold before a down switch.
// Assumes: sample_vld and cp_tick are one-cycle strobes on clk; mode is static
// between edges; reset is synchronous and active low.
module chs_rail_ctrl
    import chs_pkg::*;
#(
    parameter int SAMPLE_W     = 16,
    parameter int HOLD_SAMPLES = 264000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 mode,
    input  logic [SAMPLE_W-2:0]        clip_thresh,
    input  logic                       sample_vld,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic                       cp_tick,
    output logic                       rail_req,
    output logic                       rail_state,
    output logic                       hold_active
);

    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    rail_kind_e          kind;
    logic [2:0]          mode_q;
    logic                enter;
    logic                loud;
    logic                quiet;
    logic [SAMPLE_W-2:0] mag;
    logic                clear;
    logic                step;
    logic                expired;

    assign kind  = decode_mode(mode);
    assign enter = (mode == MODE_CODE_ADAPT) && (mode_q != MODE_CODE_ADAPT);

    // Previous mode code, used to spot entry into adaptive operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_CODE_ADAPT;
        end else begin
            mode_q <= mode;
        end
    end

    chs_mag_cmp #(
        .W (SAMPLE_W)
    ) mag_i (
        .sample_i (sample),
        .valid_i  (sample_vld),
        .thresh_i (clip_thresh),
        .loud_o   (loud),
        .quiet_o  (quiet),
        .mag_o    (mag)
    );

    chs_hold_timer #(
        .HOLD (HOLD_SAMPLES)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .step_i    (step),
        .expired_o (expired),
        .running_o (hold_active)
    );

    chs_rail_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind_i      (kind),
        .enter_i     (enter),
        .loud_i      (loud),
        .quiet_i     (quiet),
        .expired_i   (expired),
        .cp_tick_i   (cp_tick),
        .clear_o     (clear),
        .step_o      (step),
        .want_high_o (rail_state),
        .rail_req_o  (rail_req)
    );

    // R5: the most negative code saturates and is never above full scale.
    assert_mag_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($unsigned(sample) == MOST_NEG) |-> (mag == '1));

    // R5: a full-scale threshold can never be exceeded.
    assert_full_thresh_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clip_thresh == '1) |-> !loud);

    // R11: without a strobe no sample is classified.
    assert_no_strobe_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |-> (!loud && !quiet));

    // R10: entering adaptive mode starts high with an idle hold count.
    assert_enter_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (rail_state && !hold_active));

    // R8: a running hold count only exists while on the high rail.
    assert_hold_implies_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> rail_state);

endmodule

// File: tb/chs_rail_ctrl_tb_top.sv
`timescale 1ns/1ps
module chs_rail_ctrl_tb_top;

    localparam int W    = 16;
    localparam int HOLD = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [2:0]          mode = 3'b111;
    logic [W-2:0]        clip_thresh = 15'd1000;
    logic                sample_vld = 1'b0;
    logic signed [W-1:0] sample = '0;
    logic                cp_tick = 1'b0;
    logic                rail_req;
    logic                rail_state;
    logic                hold_active;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    // Reference model state.
    int m_high = 1, m_cnt = 0, m_req = 1, m_prev = 7;
    bit m_live = 0;

    always #2 clk = ~clk;

    chs_rail_ctrl #(.SAMPLE_W(W), .HOLD_SAMPLES(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .clip_thresh(clip_thresh),
        .sample_vld(sample_vld), .sample(sample), .cp_tick(cp_tick),
        .rail_req(rail_req), .rail_state(rail_state), .hold_active(hold_active)
    );

    function automatic int kind_of(input int code);
        if (code == 1) return 0;
        if (code == 7) return 2;
        return 1;
    endfunction

    function automatic int mag_of(input int s);
        if (s == -32768) return 32767;
        if (s < 0) return -s;
        return s;
    endfunction

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        int k, nreq;
        bit loud, enter;
        m_live = 1;
        if (!rst_n) begin
            m_high = 1; m_cnt = 0; m_req = 1; m_prev = 7;
        end else begin
            k     = kind_of(int'(mode));
            enter = (mode == 3'd7) && (m_prev != 7);
            loud  = sample_vld && (mag_of(int'(sample)) > int'(clip_thresh));
            nreq  = cp_tick ? m_high : m_req;
            if (k == 0) begin m_high = 0; m_cnt = 0; end
            else if (k == 1) begin m_high = 1; m_cnt = 0; end
            else if (enter || loud) begin m_high = 1; m_cnt = 0; end
            else if (sample_vld && m_high == 1) begin
                if (m_cnt == HOLD - 1) begin m_high = 0; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            m_prev = int'(mode);
            m_req  = nreq;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: compare outputs with the model, then drive the next inputs.
    task automatic step(input bit v, input int s);
        @(negedge clk);
        if (m_live) begin
            chk("R7 model rail_req", int'(rail_req), m_req);
            chk("R8 model rail_state", int'(rail_state), m_high);
            chk("R8 model hold_active", int'(hold_active), (m_cnt != 0) ? 1 : 0);
        end
        sample_vld = v;
        sample     = W'(s);
        cp_tick    = (cyc % 4 == 3);
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    initial begin
        idle(3);
        chk("R1 reset rail_req", int'(rail_req), 1);
        chk("R1 reset rail_state", int'(rail_state), 1);
        chk("R1 reset hold_active", int'(hold_active), 0);
        rst_n = 1'b1;
        idle(2);

        // Quiet run in adaptive mode down to the low rail.
        for (int i = 0; i < 4; i++) step(1, 100);
        step(0, 0);
        chk("R8 hold running", int'(hold_active), 1);
        for (int i = 0; i < 3; i++) step(1, -200);
        step(0, 0);
        chk("R8 still high before last", int'(rail_state), 1);
        step(1, 5); step(0, 0);
        chk("R8 down after full hold", int'(rail_state), 0);
        chk("R8 hold cleared", int'(hold_active), 0);
        idle(5);
        chk("R7 request follows down", int'(rail_req), 0);

        // Samples without the strobe have no effect.
        step(0, 30000); step(0, -30000); step(0, 0);
        chk("R11 no strobe ignored", int'(rail_state), 0);

        // Magnitude rules.
        clip_thresh = 15'h7FFF;
        step(1, -32768); step(0, 0);
        chk("R5 most negative saturates", int'(rail_state), 0);
        clip_thresh = 15'd1000;
        step(1, 1000); step(0, 0);
        chk("R5 equal is not loud", int'(rail_state), 0);
        step(1, -1000); step(0, 0);
        chk("R5 negative equal not loud", int'(rail_state), 0);
        step(1, -1001); step(0, 0);
        chk("R6 loud raises at once", int'(rail_state), 1);
        idle(5);
        chk("R7 request follows up", int'(rail_req), 1);

        // Restart of the hold by a loud sample.
        for (int i = 0; i < 5; i++) step(1, 10);
        step(1, 20000);
        step(0, 0);
        chk("R9 restart clears hold", int'(hold_active), 0);
        for (int i = 0; i < 5; i++) step(1, 10);
        step(0, 0);
        chk("R9 still high after restart", int'(rail_state), 1);
        for (int i = 0; i < 3; i++) step(1, 10);
        step(0, 0);
        chk("R9 down after restarted hold", int'(rail_state), 0);

        // Fixed low mode ignores loud samples.
        mode = 3'b001;
        step(1, 30000); step(1, -32768); step(0, 0);
        chk("R2 fixed low", int'(rail_state), 0);
        idle(5);
        chk("R2 fixed low request", int'(rail_req), 0);

        // Entering adaptive mode.
        mode = 3'b111;
        step(0, 0); step(0, 0);
        chk("R10 enter starts high", int'(rail_state), 1);
        chk("R10 enter hold idle", int'(hold_active), 0);
        step(1, 10); step(0, 0);
        chk("R10 hold starts after entry", int'(hold_active), 1);

        // Fixed high mode ignores quiet samples.
        mode = 3'b001; idle(2);
        mode = 3'b010;
        for (int i = 0; i < 10; i++) step(1, 1);
        step(0, 0);
        chk("R3 fixed high", int'(rail_state), 1);
        chk("R3 fixed high no hold", int'(hold_active), 0);
        idle(5);
        chk("R3 fixed high request", int'(rail_req), 1);

        // Reserved codes behave as fixed high.
        mode = 3'b001; idle(2);
        mode = 3'b100;
        for (int i = 0; i < 10; i++) step(1, 1);
        step(0, 0);
        chk("R4 reserved 100 high", int'(rail_state), 1);
        mode = 3'b001; idle(2);
        mode = 3'b000; idle(2);
        chk("R4 reserved 000 high", int'(rail_state), 1);
        idle(6);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule